// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives software access to the management registers of an Ethernet PHY through one 32-bit command/status word. A write to the word starts a management transaction. Bit 31 of the written value selects the direction: a one asks for a PHY register write and a zero asks for a PHY register read. The bridge then serialises a clause-22 management frame on the MDC clock and the MDIO data line. The PHY address is fixed by a parameter, 1 by default.

Completion is signalled through the same bit 31, which flips away from the value that software wrote. A write finishes by clearing the bit. A read finishes by setting the bit and placing the 16 bits returned by the PHY in bits 15:0. Software polls the word until the bit changes.

While a frame is in flight a busy output is high. Command writes that arrive during that time are dropped.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset the read-back word is all zeros, busy is low, MDC is low and the MDIO output enable is low.
- R2: A command with bit 31 set sends a 64-bit frame, most significant bit first, one bit per MDC period. The frame is 32 ones, then start 01, opcode 01, the 5-bit PHY address (1), the register address from command bits 20:16, turnaround 10 and the 16 data bits from command bits 15:0. The output enable is high for all 64 bits.
- R3: A write transaction keeps busy high for exactly 64·2·DIV_HALF clock cycles. At its end bit 31 of the read-back word is 0, and bits 20:16 and 15:0 still hold the address and data that were written.
- R4: A command with bit 31 clear sends the same first 46 bits as R2 but with opcode 10. The output enable is then low for the last 18 bits (turnaround and data).
- R5: At the end of a read transaction, which lasts as long as in R3, bit 31 of the read-back word is 1. Bits 15:0 hold the MDIO input values sampled at the MDC rising edges of frame bits 48 to 63, with the first sample in bit 15. Bits 20:16 keep the register address.
- R6: MDC is low whenever busy is low. While busy, MDC holds each level for exactly DIV_HALF clock cycles, giving 64 rising edges per transaction.
- R7: A command write while busy is ignored: the read-back word does not change during the transaction, and the transaction ends with the original command's values.
- R8: Bits 30:21 of the read-back word always read 0.
- R9: A command write accepted while idle raises busy in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Command word write strobe |
| wrData | input | 32 | Command word: bit 31 direction/flag, 20:16 register address, 15:0 data |
| rdData | output | 32 | Status word: flag, register address, data |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value |

## Verification
Busy is due one clock after the accepted write strobe. The bench samples it on the following falling clock edge. It then counts falling-edge samples until busy drops and compares the count with 64·2·DIV_HALF. The status word is compared on the first falling edge after busy drops, because the flag and the read data change on the same edge as busy. Frame bits are captured on each MDC rising edge. The bench PHY model changes MDIO input only on MDC falling edges, so each value is settled half an MDC period before the bridge samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W      = 16;
  localparam int REG_W       = 5;
  localparam int PHY_W       = 5;
  localparam int PRE_LEN     = 32;
  localparam int FRAME_BITS  = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int HDR_BITS    = PRE_LEN + 2 + 2 + PHY_W + REG_W;
  localparam int DATA_START  = HDR_BITS + 2;
  localparam int IDX_W       = $clog2(FRAME_BITS);

  typedef struct packed {
    logic load;
    logic sample;
    logic advance;
    logic finish;
  } mgmtStb_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic riseStb,
  output logic fallStb
);
  localparam int CNT_W = $clog2(DIV_HALF + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap    = run && (cnt == CNT_LAST);
  assign riseStb = wrap && !mdc;
  assign fallStb = wrap && mdc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (run) begin
      if (wrap) begin
        cnt <= '0;
        mdc <= !mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     opWrite,
  input  logic     riseStb,
  input  logic     fallStb,
  output logic     busy,
  output logic     mdioOe,
  output mgmtStb_t stb
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] HDR_IDX   = IDX_W'(HDR_BITS);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_START);

  logic [IDX_W-1:0] bitIdx;
  logic             lastBit;

  assign lastBit     = (bitIdx == LAST_IDX);
  assign stb.load    = wrEn && !busy;
  assign stb.sample  = busy && riseStb && !opWrite && (bitIdx >= DATA_IDX);
  assign stb.advance = busy && fallStb && !lastBit;
  assign stb.finish  = busy && fallStb && lastBit;
  assign mdioOe      = busy && (opWrite || (bitIdx < HDR_IDX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (stb.load) begin
      busy   <= 1'b1;
      bitIdx <= '0;
    end else if (stb.finish) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (stb.advance) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mgmtStb_t          stb,
  input  logic              cmdFlag,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              opWrite,
  output logic [31:0]       rdData
);
  localparam logic [PHY_W-1:0] PHY_FIELD = PHY_W'(PHY_ADDR);

  logic              flag;
  logic [REG_W-1:0]  regAddr;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] rxShift;
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] frameInit;

  always_comb begin
    if (cmdFlag)
      frameInit = {{PRE_LEN{1'b1}}, 2'b01, 2'b01, PHY_FIELD, cmdReg, 2'b10, cmdData};
    else
      frameInit = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, PHY_FIELD, cmdReg, {(2+DATA_W){1'b1}}};
  end

  assign mdioOut = txShift[FRAME_BITS-1];
  assign opWrite = flag;
  assign rdData  = {flag, {(31-REG_W-DATA_W){1'b0}}, regAddr, dataReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag    <= 1'b0;
      regAddr <= '0;
      dataReg <= '0;
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (stb.load) begin
        flag    <= cmdFlag;
        regAddr <= cmdReg;
        dataReg <= cmdData;
        txShift <= frameInit;
      end else if (stb.advance) begin
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (stb.sample)
        rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (stb.finish) begin
        txShift <= '0;
        if (flag) begin
          flag <= 1'b0;
        end else begin
          flag    <= 1'b1;
          dataReg <= rxShift;
        end
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int PHY_ADDR = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        busy,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mgmtStb_t stb;
  logic     riseStb;
  logic     fallStb;
  logic     opWrite;
  logic     unusedWrBits;

  assign unusedWrBits = ^wrData[30:REG_W+DATA_W];

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) i_div (
    .clk(clk), .rstN(rstN), .start(stb.load), .run(busy),
    .mdc(mdc), .riseStb(riseStb), .fallStb(fallStb)
  );

  mdio_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .opWrite(opWrite),
    .riseStb(riseStb), .fallStb(fallStb),
    .busy(busy), .mdioOe(mdioOe), .stb(stb)
  );

  mdio_datapath #(.PHY_ADDR(PHY_ADDR)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdFlag(wrData[31]), .cmdReg(wrData[REG_W+DATA_W-1:DATA_W]),
    .cmdData(wrData[DATA_W-1:0]), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .opWrite(opWrite), .rdData(rdData)
  );
endmodule

// File: rtl/phy_mgmt_bridge_chk.sv
module phy_mgmt_bridge_chk #(
  parameter int DIV_HALF = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        wrFlag,
  input logic [31:0] rdData,
  input logic        busy,
  input logic        mdc,
  input logic        mdioOe
);
  logic        cmdWrite;
  logic        prevMdc;
  logic [15:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWrite <= 1'b0;
      prevMdc  <= 1'b0;
      holdCnt  <= '0;
    end else begin
      prevMdc <= mdc;
      if (wrEn && !busy) begin
        cmdWrite <= wrFlag;
        holdCnt  <= '0;
      end else if (mdc != prevMdc) begin
        holdCnt <= 16'd1;
      end else if (holdCnt != 16'hFFFF) begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy) |=> busy); // R9
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && cmdWrite) |-> !rdData[31]); // R3
  AST_READ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !cmdWrite) |-> rdData[31]); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R6
  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (mdc != prevMdc)) |-> (holdCnt == 16'(DIV_HALF))); // R6
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdData)); // R7
endmodule

bind phy_mgmt_bridge phy_mgmt_bridge_chk #(.DIV_HALF(DIV_HALF)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrFlag(wrData[31]),
  .rdData(rdData), .busy(busy), .mdc(mdc), .mdioOe(mdioOe)
);

// File: tb/test_phy_mgmt_bridge.sv
module test_phy_mgmt_bridge;
  localparam int DIV_HALF = 2;
  localparam int OP_CYCLES = 64 * 2 * DIV_HALF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        busy, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int fails  = 0;
  int riseCnt = 0;
  logic [15:0] phyRdVal = '0;
  logic [63:0] capOut, capOe;

  always #4 clk = !clk;

  phy_mgmt_bridge #(.DIV_HALF(DIV_HALF), .PHY_ADDR(1)) i_phy_mgmt_bridge (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .busy(busy), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capOut[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]  = mdioOe;
    end
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    if (riseCnt >= 48 && riseCnt < 64) mdioIn = phyRdVal[63-riseCnt];
    else mdioIn = 1'b1;
  end

  function automatic logic [63:0] expFrame(input logic wr, input logic [4:0] ra, input logic [15:0] d);
    if (wr) return {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, ra, 2'b10, d};
    else    return {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd1, ra, 18'h0};
  endfunction

  function automatic logic [63:0] expOe(input logic wr);
    if (wr) return {64{1'b1}};
    else    return {{46{1'b1}}, 18'h0};
  endfunction

  function automatic logic [31:0] expWord(input logic wr, input logic [4:0] ra, input logic [15:0] d, input logic [15:0] rv);
    if (wr) return {1'b0, 10'h0, ra, d};
    else    return {1'b1, 10'h0, ra, rv};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic wr, input logic [4:0] ra, input logic [15:0] d,
                       input logic [15:0] rv, input logic poke);
    int n;
    logic [31:0] cmd;
    cmd = {wr, 10'h2A5, ra, d};
    phyRdVal = rv;
    riseCnt = 0;
    @(negedge clk);
    wrEn = 1'b1; wrData = cmd;
    @(negedge clk);
    wrEn = 1'b0; wrData = ~cmd;
    check("R9 busy after accept", 64'(busy), 64'd1);
    n = 0;
    while (busy && n < OP_CYCLES + 50) begin
      if (poke && n == 40) begin
        wrEn = 1'b1; wrData = {~wr, 10'h0, ~ra, ~d};
      end else begin
        wrEn = 1'b0;
      end
      if (poke && n == 60)
        check("R7 word held while busy", 64'(rdData), 64'({wr, 10'h0, ra, d}));
      n++;
      @(negedge clk);
    end
    wrEn = 1'b0;
    check(wr ? "R3 write duration" : "R5 read duration", 64'(n), 64'(OP_CYCLES));
    check("R6 mdc rising edges", 64'(riseCnt), 64'd64);
    check("R6 idle mdc/oe", {62'h0, mdc, mdioOe}, 64'h0);
    check(wr ? "R2 write frame" : "R4 read frame", capOut & expOe(wr), expFrame(wr, ra, d));
    check(wr ? "R2 write oe" : "R4 read oe release", capOe, expOe(wr));
    check(wr ? "R3 R8 write status" : "R5 R8 read status", 64'(rdData), 64'(expWord(wr, ra, d, rv)));
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd1234);
    #5;
    @(negedge clk);
    check("R1 reset word", 64'(rdData), 64'h0);
    check("R1 reset pins", {61'h0, busy, mdc, mdioOe}, 64'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {rdData, 29'h0, busy, mdc, mdioOe}, 64'h0);
    runOp(1'b1, 5'd0,  16'h0000, 16'h0000, 1'b0);
    runOp(1'b1, 5'd31, 16'hFFFF, 16'h0000, 1'b0);
    runOp(1'b0, 5'd31, 16'h0000, 16'hA5C3, 1'b0);
    runOp(1'b0, 5'd0,  16'h1234, 16'h0000, 1'b0);
    runOp(1'b1, 5'd11, 16'h8001, 16'h0000, 1'b1);
    runOp(1'b0, 5'd7,  16'h0F0F, 16'h8001, 1'b1);
    for (int i = 0; i < 10; i++) begin
      logic [31:0] r;
      r = $urandom();
      runOp(r[31], r[20:16], r[15:0], 16'($urandom()), r[24]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule